// File: doc/BRIEF.md
# Single-Wire Slave Slot Timing Engine

This block is the line-facing timing engine of a slave on a single-wire, open-drain bus. It sees the bus only through a raw input and acts on it only through a pull-low enable. The master controls the timing of every bus event. The slave therefore times each of its actions from a falling edge it has detected on the line.

A long low period from the master is a bus reset. The engine answers a reset by waiting a short time and then pulling the line low for a presence interval. If another slave pulls the line low first, the engine skips its own presence pulse.

After that the engine handles one data bit per slot:
- **Write slots:** the master sends a bit. The engine samples the line a fixed delay after the falling edge and hands the value upward as a one-cycle strobe.
- **Read slots:** the upper layer asks to send a bit by holding `tx_req` high with the bit on `tx_bit`. A zero is sent by pulling the line low for a hold interval. A one is sent by leaving the line released.

Byte assembly belongs to the layer above, which shifts least significant bit first. Every interval is a parameter counted in clock cycles.

Top module: `owslv_phy`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `line_pull`, `bit_valid`, `tx_taken` and `reset_seen` are all 0.
- R2: A low period on the synchronized line of at least RST_CYC cycles (480 by default) is a reset. It is recognised on the rising edge that ends the low period. `reset_seen` then pulses for exactly one cycle, 3 cycles after the line input rises. A low period of RST_CYC-1 cycles gives no pulse.
- R3: After `reset_seen`, `line_pull` stays 0 for PWAIT_CYC cycles. It is then 1 for exactly PPULSE_CYC consecutive cycles, and then returns to 0.
- R4: If a falling edge is seen during the presence wait, `line_pull` stays 0 and no presence pulse is sent. The engine is ready for data slots directly after that edge.
- R5: In a slot where `tx_req` is 0 at the falling edge, `bit_valid` pulses once, SAMPLE_CYC+3 cycles after the line input falls. `bit_data` carries the sampled line level, with high meaning 1 and low meaning 0.
- R6: In a slot where `tx_req` is 1 and `tx_bit` is 0 at the falling edge:
  - `tx_taken` pulses once.
  - `line_pull` is 1 for exactly HOLD_CYC cycles.
  - No `bit_valid` pulse is produced.
- R7: In a slot where `tx_req` is 1 and `tx_bit` is 1, `tx_taken` pulses once. `line_pull` stays 0, so the master reads a high level.
- R8: While the engine pulls the line low, line edges start no slot. Its own release also starts no slot, so it produces no extra `bit_valid` or `tx_taken`.
- R9: Before the first reset, falling edges are ignored: no `bit_valid`, no `tx_taken` and no pull, whatever `tx_req` holds.
- R10: A reset-length low period is recognised in the middle of a data transfer, including one that begins while the engine is holding its own zero bit. It restarts the presence sequence.
- R11: Bits are delivered one per slot, in the order of the slots. A byte written least significant bit first is therefore reassembled unchanged when the bits are shifted in LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw bus level, asynchronous |
| line_pull | output | 1 | 1 = pull the bus low (open-drain enable) |
| tx_req | input | 1 | Level: the next slot is a read slot that sends `tx_bit` |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_taken | output | 1 | One-cycle pulse: `tx_bit` was consumed by a slot |
| bit_valid | output | 1 | One-cycle pulse: a written bit was sampled |
| bit_data | output | 1 | Sampled bit, valid with `bit_valid` |
| reset_seen | output | 1 | One-cycle pulse: a bus reset was recognised |

## Verification
A wrong state in the slot sequencer shows up at the ports within one slot. The typical symptoms are:
- a pull that is missing, or that lasts the presence length where the hold length belongs;
- a strobe with no matching slot;
- a strobe that lands a few cycles away from its fixed latency.

A corrupted low-period count shows up only at the next rising edge. It appears as a missing or spurious `reset_seen`, which the exact-threshold tests locate. An engine that wrongly believes it is armed answers slots before any reset. The engine's own release edge must not be treated as a new slot; if it is, the error appears as an extra strobe about HOLD_CYC cycles after the falling edge.

// File: rtl/owslv_pkg.sv
package owslv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,    // no reset seen yet, slots ignored
    ST_PWAIT,   // waiting before the presence pulse
    ST_PPULSE,  // driving the presence pulse
    ST_READY,   // waiting for a slot falling edge
    ST_SAMPLE,  // timing the write-slot sample point
    ST_HOLD     // holding the line low for a zero bit
  } slot_st_e;
endpackage

// File: rtl/owslv_sync.sv
module owslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dsync,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign dsync = chain[STAGES-1];
  assign fall  = prev & ~dsync;
  assign rise  = ~prev & dsync;
endmodule

// File: rtl/owslv_lowtimer.sv
module owslv_lowtimer #(
  parameter int RST_CYC = 480
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  input  logic rise,
  output logic rst_evt
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RST_CYC);

  logic [CW-1:0] low_cnt;

  // counts low cycles, saturating at the reset threshold
  always_ff @(posedge clk) begin
    if (rst)            low_cnt <= '0;
    else if (line_s)    low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + CW'(1);
  end

  assign rst_evt = rise && (low_cnt == LIMIT);
endmodule

// File: rtl/owslv_slotfsm.sv
module owslv_slotfsm
  import owslv_pkg::*;
#(
  parameter int PWAIT_CYC  = 30,
  parameter int PPULSE_CYC = 120,
  parameter int SAMPLE_CYC = 30,
  parameter int HOLD_CYC   = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  input  logic fall,
  input  logic rst_evt,
  input  logic tx_req,
  input  logic tx_bit,
  output logic line_pull,
  output logic bit_valid,
  output logic bit_data,
  output logic tx_taken,
  output logic reset_seen
);
  localparam int M1   = (PWAIT_CYC  > PPULSE_CYC) ? PWAIT_CYC  : PPULSE_CYC;
  localparam int M2   = (SAMPLE_CYC > HOLD_CYC)   ? SAMPLE_CYC : HOLD_CYC;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXT + 1);

  slot_st_e        st;
  logic [TW-1:0]   tmr;
  logic            tmr_done;

  assign tmr_done = (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      tmr        <= '0;
      line_pull  <= 1'b0;
      bit_valid  <= 1'b0;
      bit_data   <= 1'b0;
      tx_taken   <= 1'b0;
      reset_seen <= 1'b0;
    end else begin
      bit_valid  <= 1'b0;
      tx_taken   <= 1'b0;
      reset_seen <= 1'b0;
      if (rst_evt) begin
        st         <= ST_PWAIT;
        tmr        <= TW'(PWAIT_CYC - 1);
        line_pull  <= 1'b0;
        reset_seen <= 1'b1;
      end else begin
        case (st)
          ST_IDLE: ;
          ST_PWAIT: begin
            if (fall) begin
              st <= ST_READY;             // another slave answered
            end else if (tmr_done) begin
              st        <= ST_PPULSE;
              tmr       <= TW'(PPULSE_CYC - 1);
              line_pull <= 1'b1;
            end else begin
              tmr <= tmr - TW'(1);
            end
          end
          ST_PPULSE: begin
            if (tmr_done) begin
              st        <= ST_READY;
              line_pull <= 1'b0;
            end else begin
              tmr <= tmr - TW'(1);
            end
          end
          ST_READY: begin
            if (fall) begin
              if (tx_req) begin
                tx_taken <= 1'b1;
                if (!tx_bit) begin
                  st        <= ST_HOLD;
                  tmr       <= TW'(HOLD_CYC - 1);
                  line_pull <= 1'b1;
                end
              end else begin
                st  <= ST_SAMPLE;
                tmr <= TW'(SAMPLE_CYC - 1);
              end
            end
          end
          ST_SAMPLE: begin
            if (tmr_done) begin
              bit_valid <= 1'b1;
              bit_data  <= line_s;
              st        <= ST_READY;
            end else begin
              tmr <= tmr - TW'(1);
            end
          end
          ST_HOLD: begin
            if (tmr_done) begin
              st        <= ST_READY;
              line_pull <= 1'b0;
            end else begin
              tmr <= tmr - TW'(1);
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/owslv_phy.sv
module owslv_phy #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC     = 480,
  parameter int PWAIT_CYC   = 30,
  parameter int PPULSE_CYC  = 120,
  parameter int SAMPLE_CYC  = 30,
  parameter int HOLD_CYC    = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_pull,
  input  logic tx_req,
  input  logic tx_bit,
  output logic tx_taken,
  output logic bit_valid,
  output logic bit_data,
  output logic reset_seen
);
  logic line_s, fall, rise, rst_evt;

  owslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(line_in),
    .dsync(line_s), .fall(fall), .rise(rise)
  );

  owslv_lowtimer #(.RST_CYC(RST_CYC)) u_low (
    .clk(clk), .rst(rst), .line_s(line_s), .rise(rise), .rst_evt(rst_evt)
  );

  owslv_slotfsm #(
    .PWAIT_CYC(PWAIT_CYC), .PPULSE_CYC(PPULSE_CYC),
    .SAMPLE_CYC(SAMPLE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .line_s(line_s), .fall(fall), .rst_evt(rst_evt),
    .tx_req(tx_req), .tx_bit(tx_bit),
    .line_pull(line_pull), .bit_valid(bit_valid), .bit_data(bit_data),
    .tx_taken(tx_taken), .reset_seen(reset_seen)
  );
endmodule

// File: rtl/owslv_phy_chk.sv
module owslv_phy_chk #(
  parameter int PPULSE_CYC = 120,
  parameter int HOLD_CYC   = 30
) (
  input logic clk,
  input logic rst,
  input logic line_pull,
  input logic tx_taken,
  input logic bit_valid,
  input logic reset_seen
);
  localparam int MAXP = (PPULSE_CYC > HOLD_CYC) ? PPULSE_CYC : HOLD_CYC;
  localparam int RW   = $clog2(MAXP + 2);

  logic          armed;
  logic [RW-1:0] pull_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      pull_run <= '0;
    end else begin
      if (reset_seen) armed <= 1'b1;
      if (!line_pull)            pull_run <= '0;
      else if (pull_run != '1)   pull_run <= pull_run + RW'(1);
    end
  end

  // R1: outputs quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!line_pull && !bit_valid && !tx_taken && !reset_seen));

  // R2: reset indication is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    reset_seen |=> !reset_seen);

  // R5: sample strobe is a single-cycle pulse
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  // R8: one slot never produces both a sampled bit and a taken bit
  a_r8_one_action: assert property (@(posedge clk) disable iff (rst)
    !(bit_valid && tx_taken));

  // R9: nothing happens on the line side before a reset was recognised
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!line_pull && !bit_valid && !tx_taken));

  // R3 / R6: no pull lasts longer than the longest pull interval
  a_r3_pull_bounded: assert property (@(posedge clk) disable iff (rst)
    pull_run <= RW'(MAXP));
endmodule

bind owslv_phy owslv_phy_chk #(.PPULSE_CYC(PPULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst(rst), .line_pull(line_pull), .tx_taken(tx_taken),
  .bit_valid(bit_valid), .reset_seen(reset_seen)
);

// File: tb/sim_owslv_phy.sv
module sim_owslv_phy;
  localparam int RST_CYC    = 480;
  localparam int PWAIT_CYC  = 30;
  localparam int PPULSE_CYC = 120;
  localparam int SAMPLE_CYC = 30;
  localparam int HOLD_CYC   = 30;
  localparam int NVEC       = 12;
  // vector: {is_read_slot, bit}
  localparam logic [1:0] VEC [0:NVEC-1] = '{
    2'b01, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b01,
    2'b10, 2'b11, 2'b11, 2'b10
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_low = 1'b0;
  logic other_low  = 1'b0;
  logic tx_req = 1'b0;
  logic tx_bit = 1'b0;
  logic line_in, line_pull, tx_taken, bit_valid, bit_data, reset_seen;

  int nchk = 0;
  int nfail = 0;
  int n_rs = 0, n_bv = 0, n_tk = 0, n_pull = 0;
  logic last_bd = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign line_in = !(master_low || other_low || line_pull);

  owslv_phy #(
    .RST_CYC(RST_CYC), .PWAIT_CYC(PWAIT_CYC), .PPULSE_CYC(PPULSE_CYC),
    .SAMPLE_CYC(SAMPLE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u0 (
    .clk(clk), .rst(rst), .line_in(line_in), .line_pull(line_pull),
    .tx_req(tx_req), .tx_bit(tx_bit), .tx_taken(tx_taken),
    .bit_valid(bit_valid), .bit_data(bit_data), .reset_seen(reset_seen)
  );

  always @(negedge clk) begin
    if (reset_seen) n_rs <= n_rs + 1;
    if (bit_valid) begin n_bv <= n_bv + 1; last_bd <= bit_data; end
    if (tx_taken)  n_tk <= n_tk + 1;
    if (line_pull) n_pull <= n_pull + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk);
    n_rs = 0; n_bv = 0; n_tk = 0; n_pull = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // master write slot, 80 cycles long
  task automatic wslot(input logic b);
    int lo;
    lo = b ? 6 : 60;
    master_low = 1'b1; tick(lo);
    master_low = 1'b0; tick(80 - lo);
  endtask

  // master read slot: returns the level at 15 cycles after the falling edge
  task automatic rslot(output logic seen);
    master_low = 1'b1; tick(4);
    master_low = 1'b0; tick(11);
    seen = line_in;
    tx_req = 1'b0;
    tick(65);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic seen;
    logic [7:0] rxbyte;
    int nrx;

    tick(5);
    chk("R1 line_pull", int'(line_pull), 0);
    chk("R1 bit_valid", int'(bit_valid), 0);
    chk("R1 reset_seen", int'(reset_seen), 0);
    rst = 1'b0;
    tick(1);
    chk("R1 tx_taken", int'(tx_taken), 0);

    // R9: slots before any reset are ignored
    clr();
    tx_req = 1'b1; tx_bit = 1'b0;
    wslot(1'b0);
    tx_req = 1'b0;
    wslot(1'b1);
    tick(20);
    chk("R9 pull", n_pull, 0);
    chk("R9 taken", n_tk, 0);
    chk("R9 valid", n_bv, 0);

    // R2: just under the threshold gives no reset
    clr();
    master_low = 1'b1; tick(RST_CYC - 1);
    master_low = 1'b0; tick(40);
    chk("R2 short low", n_rs, 0);

    // R2/R3: exact threshold
    clr();
    master_low = 1'b1; tick(RST_CYC);
    master_low = 1'b0;
    cnt = 0;
    do begin tick(1); cnt++; end while (!reset_seen && cnt < 50);
    chk("R2 reset latency", cnt, 3);
    cnt = 0;
    do begin tick(1); cnt++; end while (!line_pull && cnt < 200);
    chk("R3 presence wait", cnt, PWAIT_CYC);
    cnt = 1;
    while (cnt < 400) begin
      tick(1);
      if (!line_pull) break;
      cnt++;
    end
    chk("R3 presence length", cnt, PPULSE_CYC);
    chk("R2 one pulse", n_rs, 1);
    tick(20);

    // vector walk: R5 write slots, R6/R7 read slots, R11 order
    rxbyte = 8'h00; nrx = 0;
    for (int i = 0; i < NVEC; i++) begin
      clr();
      if (VEC[i][1]) begin
        tx_req = 1'b1; tx_bit = VEC[i][0];
        rslot(seen);
        chk(VEC[i][0] ? "R7 read level" : "R6 read level", int'(seen), int'(VEC[i][0]));
        chk("R6 taken", n_tk, 1);
      end else begin
        wslot(VEC[i][0]);
        chk("R5 bit", int'(last_bd), int'(VEC[i][0]));
        chk("R5 valid count", n_bv, 1);
        rxbyte = {last_bd, rxbyte[7:1]};
        nrx++;
      end
    end
    chk("R11 byte", int'(rxbyte), 8'hA5);

    // R5: sample latency
    clr();
    master_low = 1'b1;
    cnt = 0;
    do begin
      tick(1); cnt++;
      if (cnt == 60) master_low = 1'b0;
    end while (!bit_valid && cnt < 200);
    master_low = 1'b0;
    chk("R5 latency", cnt, SAMPLE_CYC + 3);
    chk("R5 zero", int'(bit_data), 0);
    tick(40);

    // R6/R8: zero hold length, own release starts nothing
    clr();
    tx_req = 1'b1; tx_bit = 1'b0;
    rslot(seen);
    tick(100);
    chk("R6 hold length", n_pull, HOLD_CYC);
    chk("R8 taken once", n_tk, 1);
    chk("R8 no valid", n_bv, 0);

    // R7: one bit never pulls
    clr();
    tx_req = 1'b1; tx_bit = 1'b1;
    rslot(seen);
    chk("R7 no pull", n_pull, 0);

    // R4: another slave answers during the presence wait
    master_low = 1'b1; tick(600);
    master_low = 1'b0;
    cnt = 0;
    do begin tick(1); cnt++; end while (!reset_seen && cnt < 50);
    clr();
    tick(9);
    other_low = 1'b1; tick(60);
    other_low = 1'b0; tick(200);
    chk("R4 no presence", n_pull, 0);
    clr();
    wslot(1'b1);
    chk("R4 ready valid", n_bv, 1);
    chk("R4 ready bit", int'(last_bd), 1);

    // R10: reset in the middle of a zero transmission
    tx_req = 1'b1; tx_bit = 1'b0;
    master_low = 1'b1; tick(50);
    tx_req = 1'b0; tick(550);
    master_low = 1'b0;
    clr();
    tick(300);
    chk("R10 reset seen", n_rs, 1);
    chk("R10 presence", n_pull, PPULSE_CYC);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule